// File: doc/BRIEF.md
# Per-Cycle Timing Event Log Writer

This block keeps a compact log of machine timing events, so that software can find where each machine cycle's data begins in the bulk data table. Six single-cycle event strobes arrive: cycle start, cycle stop, calibration start, calibration stop, injection and harmonic change. Each clock in which at least one strobe is high produces at most one 32-bit log entry. The entry is written to a 64-word memory through a plain write port.

The memory works as a ring of four cycle blocks of sixteen slots each. The block is chosen by the two low bits of an internal cycle counter, and the slot by a per-cycle event counter. The block also keeps a count of machine cycles and the number of milliseconds since the latest cycle start. The millisecond length is a parameter given in clock cycles.

Top module: `cycle_event_logger`

## Requirements
- R1: After reset, `wr_en_o` is 0, `cycle_num_o` is 0, `ms_count_o` is 0 and `last_addr_o` is 0.
- R2: An entry has the event code in bits 31:24 and, in bits 23:0, the pointer value present on `data_ptr_i` during the strobe cycle. In the code, strobe `evt_i[k]` appears at bit k+1 and bits 0 and 7 are zero. The strobe indices are: 0 cycle start, 1 cycle stop, 2 calibration start, 3 calibration stop, 4 injection, 5 harmonic change. The write (`wr_en_o` high) happens in the clock after the strobe.
- R3: The write address is {cycle_num[1:0], slot[3:0]}: the cycle number in bits 5:4 and the slot in bits 3:0.
- R4: A cycle-start strobe increments `cycle_num_o` on the same edge that presents its entry. That entry goes to slot 0 of the new cycle's block. The next recorded event uses slot 1. Without a start strobe the cycle number is unchanged.
- R5: Strobes that are not cycle start go to the next slot, and each recorded entry advances the slot by one. Strobes high in the same clock are merged into one entry.
- R6: After slot 15 of a cycle has been written, further strobes in that cycle produce no write, until the next cycle start.
- R7: `ms_count_o` is 0 on the edge after a cycle-start strobe. It then increments once every `TICKS_PER_MS` clocks.
- R8: `last_addr_o` holds the address of the most recent write, one clock after that write.
- R9: A clock with no strobe high produces no write in the following clock.
- R10: The fifth cycle reuses the address block of the first cycle, so four cycle blocks form a ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | Timing event strobes, indices as in R2 |
| data_ptr_i | input | 24 | Current write pointer into the bulk data table |
| wr_en_o | output | 1 | Log memory write enable |
| wr_addr_o | output | 6 | Log memory write address |
| wr_data_o | output | 32 | Log memory write data |
| cycle_num_o | output | 32 | Machine cycle count |
| ms_count_o | output | 32 | Milliseconds since the latest cycle start |
| last_addr_o | output | 6 | Address of the latest write |

## Verification
Every log write is due exactly one clock after its strobe. The driver task pushes the expected address and data when it applies a strobe. The monitor compares each write at the falling edge that follows it, and any write with nothing queued counts as a failure, which is how dropped strobes are checked.

The cycle number is read at the falling edge after the strobe edge. `last_addr_o` is read one clock later than the write it reflects. The millisecond count is read `TICKS_PER_MS - 1` and `TICKS_PER_MS` clocks after the start edge, on both sides of its first increment.

// File: rtl/cel_pkg.sv
package cel_pkg;
   localparam int EVT_N      = 6;
   localparam int CODE_W     = 8;
   localparam int EVT_START  = 0;
   localparam int CODE_SHIFT = 1;
endpackage

// File: rtl/cel_ms_timer.sv
module cel_ms_timer #(
   parameter int TICKS_PER_MS = 125000,
   parameter int MS_W         = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   output logic [MS_W-1:0] ms_o
);
   generate
      if (TICKS_PER_MS < 1) begin : g_bad
         $error("TICKS_PER_MS must be at least 1");
      end
      if (TICKS_PER_MS == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n || restart) ms_o <= '0;
            else                   ms_o <= ms_o + 1'b1;
         end
      end else begin : g_prescale
         localparam int TW = $clog2(TICKS_PER_MS);
         localparam logic [TW-1:0] TLAST = TW'(TICKS_PER_MS - 1);
         logic [TW-1:0] tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
               tick_q <= '0;
               ms_o   <= '0;
            end else if (tick_q == TLAST) begin
               tick_q <= '0;
               ms_o   <= ms_o + 1'b1;
            end else begin
               tick_q <= tick_q + 1'b1;
            end
         end
      end
   endgenerate

   assert_ms_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> ms_o == '0);
endmodule

// File: rtl/cel_slot_ctrl.sv
module cel_slot_ctrl #(
   parameter int CYC_W     = 32,
   parameter int CYC_SEL_W = 2,
   parameter int SLOT_W    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic                        any_i,
   output logic                        wr_en_o,
   output logic [CYC_SEL_W+SLOT_W-1:0] addr_o,
   output logic [CYC_W-1:0]            cycle_o
);
   localparam logic [SLOT_W-1:0] SLOT_FIRST = SLOT_W'(1);

   generate
      if (SLOT_W < 1 || CYC_SEL_W < 1 || CYC_SEL_W > CYC_W) begin : g_bad
         $error("bad slot or cycle-select width");
      end
   endgenerate

   logic [SLOT_W-1:0] slot_q;
   logic              full_q;
   logic [CYC_W-1:0]  cyc_next;

   assign cyc_next = cycle_o + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cycle_o <= '0;
         slot_q  <= '0;
         full_q  <= 1'b0;
         wr_en_o <= 1'b0;
         addr_o  <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_i) begin
            cycle_o <= cyc_next;
            wr_en_o <= 1'b1;
            addr_o  <= {cyc_next[CYC_SEL_W-1:0], {SLOT_W{1'b0}}};
            slot_q  <= SLOT_FIRST;
            full_q  <= 1'b0;
         end else if (any_i && !full_q) begin
            wr_en_o <= 1'b1;
            addr_o  <= {cycle_o[CYC_SEL_W-1:0], slot_q};
            if (slot_q == {SLOT_W{1'b1}}) full_q <= 1'b1;
            else                          slot_q <= slot_q + 1'b1;
         end
      end
   end

   assert_slot0_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> wr_en_o && addr_o[SLOT_W-1:0] == '0);
   assert_cycle_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> cycle_o == $past(cycle_o) + 1'b1);
   assert_cycle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(cycle_o));
   assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !any_i |=> !wr_en_o);
   assert_block_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> addr_o[CYC_SEL_W+SLOT_W-1:SLOT_W] == cycle_o[CYC_SEL_W-1:0]);
endmodule

// File: rtl/cel_entry_fmt.sv
module cel_entry_fmt
   import cel_pkg::*;
#(
   parameter int PTR_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [EVT_N-1:0]        evt_i,
   input  logic [PTR_W-1:0]        ptr_i,
   output logic [CODE_W+PTR_W-1:0] entry_o
);
   generate
      if (EVT_N + CODE_SHIFT > CODE_W) begin : g_bad
         $error("event code does not fit its field");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   genvar k;
   generate
      for (k = 0; k < CODE_W; k++) begin : g_code
         if (k >= CODE_SHIFT && k < EVT_N + CODE_SHIFT) begin : g_map
            assign code[k] = evt_i[k-CODE_SHIFT];
         end else begin : g_zero
            assign code[k] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       entry_o <= '0;
      else if (|evt_i)  entry_o <= {code, ptr_i};
   end
endmodule

// File: rtl/cycle_event_logger.sv
module cycle_event_logger
   import cel_pkg::*;
#(
   parameter int PTR_W        = 24,
   parameter int CYC_W        = 32,
   parameter int MS_W         = 32,
   parameter int CYC_SEL_W    = 2,
   parameter int SLOT_W       = 4,
   parameter int TICKS_PER_MS = 125000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [5:0]                  evt_i,
   input  logic [PTR_W-1:0]            data_ptr_i,
   output logic                        wr_en_o,
   output logic [CYC_SEL_W+SLOT_W-1:0] wr_addr_o,
   output logic [CODE_W+PTR_W-1:0]     wr_data_o,
   output logic [CYC_W-1:0]            cycle_num_o,
   output logic [MS_W-1:0]             ms_count_o,
   output logic [CYC_SEL_W+SLOT_W-1:0] last_addr_o
);
   logic start, any_evt;
   assign start   = evt_i[EVT_START];
   assign any_evt = |evt_i;

   cel_slot_ctrl #(.CYC_W(CYC_W), .CYC_SEL_W(CYC_SEL_W), .SLOT_W(SLOT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .start_i(start), .any_i(any_evt),
      .wr_en_o(wr_en_o), .addr_o(wr_addr_o), .cycle_o(cycle_num_o));

   cel_entry_fmt #(.PTR_W(PTR_W)) u_fmt (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ptr_i(data_ptr_i), .entry_o(wr_data_o));

   cel_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_ms (
      .clk(clk), .rst_n(rst_n), .restart(start), .ms_o(ms_count_o));

   always_ff @(posedge clk) begin
      if (!rst_n)       last_addr_o <= '0;
      else if (wr_en_o) last_addr_o <= wr_addr_o;
   end

   assert_code_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !wr_data_o[CODE_W+PTR_W-1] && !wr_data_o[PTR_W]
                  && wr_data_o[CODE_W+PTR_W-1:PTR_W] != '0);
   assert_last_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> last_addr_o == $past(wr_addr_o));
endmodule

// File: tb/sim_cycle_event_logger.sv
`timescale 1ns/1ps
module sim_cycle_event_logger;
   localparam int TICKS = 5;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  evt_i = '0;
   logic [23:0] data_ptr_i = '0;
   logic        wr_en_o;
   logic [5:0]  wr_addr_o, last_addr_o;
   logic [31:0] wr_data_o, cycle_num_o, ms_count_o;

   always #2.5 clk = ~clk;

   cycle_event_logger #(.TICKS_PER_MS(TICKS)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .data_ptr_i(data_ptr_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .cycle_num_o(cycle_num_o), .ms_count_o(ms_count_o), .last_addr_o(last_addr_o));

   int checks = 0, errors = 0;
   logic [37:0] expq[$];
   int   mcyc = 0, mslot = 0;
   bit   mfull = 0;
   bit   finished = 0;

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: applies one strobe clock and queues what the log should receive
   task automatic strobe(logic [5:0] e, logic [23:0] p);
      logic [5:0] a;
      @(negedge clk);
      evt_i = e; data_ptr_i = p;
      if (e[0]) begin
         mcyc++;
         a = {mcyc[1:0], 4'd0};
         expq.push_back({a, 1'b0, e, 1'b0, p});
         mslot = 1; mfull = 0;
      end else if (e != 0 && !mfull) begin
         a = {mcyc[1:0], mslot[3:0]};
         expq.push_back({a, 1'b0, e, 1'b0, p});
         if (mslot == 15) mfull = 1; else mslot++;
      end
      @(negedge clk);
      evt_i = '0;
   endtask

   // monitor: every write must match the oldest queued item
   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         if (expq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R6/R9 unexpected write actual=%0h:%0h expected=none",
                     wr_addr_o, wr_data_o);
         end else begin
            logic [37:0] x;
            x = expq.pop_front();
            check("R2/R3/R5 entry", {wr_addr_o, wr_data_o}, x);
         end
      end
   end

   initial begin
      #(5ns * 20000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 wr_en", wr_en_o, 0);
      check("R1 cycle", cycle_num_o, 0);
      check("R1 ms", ms_count_o, 0);
      check("R1 last_addr", last_addr_o, 0);

      // R9: idle clocks produce no write
      repeat (4) @(negedge clk);
      check("R9 idle", wr_en_o, 0);

      // R4: cycle start to slot 0 of block 1
      strobe(6'b000001, 24'h00A100);
      check("R4 cycle after start", cycle_num_o, 1);
      check("R7 ms zero after start", ms_count_o, 0);
      repeat (TICKS - 1) @(negedge clk);
      check("R7 ms before tick", ms_count_o, 0);
      @(negedge clk);
      check("R7 ms after tick", ms_count_o, 1);
      check("R8 last_addr slot0", last_addr_o, 6'h10);

      // R5: sequential events and merged events
      strobe(6'b000100, 24'h00A200);
      strobe(6'b001000, 24'h00A300);
      strobe(6'b110000, 24'h00A400);
      strobe(6'b000010, 24'hFFFFFF);
      @(negedge clk);
      check("R8 last_addr", last_addr_o, 6'h14);
      check("R4 cycle stable", cycle_num_o, 1);

      // R6: fill remaining slots, then events dropped
      for (int i = 5; i < 16; i++) strobe(6'b100000, 24'(i));
      strobe(6'b010000, 24'h123456);
      strobe(6'b000010, 24'h654321);
      repeat (2) @(negedge clk);
      check("R6 last_addr stays slot15", last_addr_o, 6'h1F);

      // R4/R10: start with merged strobe; ring wrap over four cycles
      strobe(6'b100001, 24'h0B0000);
      check("R4 slot reset cycle", cycle_num_o, 2);
      strobe(6'b000100, 24'h0B0001);
      strobe(6'b000001, 24'h0C0000);
      strobe(6'b000001, 24'h0D0000);
      strobe(6'b001000, 24'h0D0001);
      strobe(6'b000001, 24'h0E0000);
      check("R10 cycle 5", cycle_num_o, 5);
      @(negedge clk);
      check("R10 wrap to block 1", last_addr_o, 6'h10);
      strobe(6'b010000, 24'h0E0001);
      repeat (2) @(negedge clk);
      check("R10 wrap slot1", last_addr_o, 6'h11);

      check("R6 queue drained", expq.size(), 0);
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule